// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A 32-pin general-purpose I/O port controlled through a small memory-mapped register bank of 32-bit words. Software sets an output value and a per-pin output-enable. It reads the synchronised pad levels back through a read-only word. Every pin feeds an interrupt detector that can watch for a low level, a high level, a rising edge or a falling edge. A separate per-pin bit makes a pin flag on any transition, whatever its 2-bit mode field holds.

Detected events set sticky flag bits. Software clears a flag by writing a one to it. A mask word lets a flag reach one of two interrupt lines: one for the lower half of the pins and one for the upper half. The register interface is a plain single-cycle write port with a combinational read port. It has no handshake and never stalls, because reads have no side effects and every write completes on the clock edge where it is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every word reads 0 and both interrupt lines are low. After reset the output value, output-enable, mode words, mask and any-edge words read 0, so the interrupt lines stay low until a mask bit is written.
- R2: A write to byte offset 0x00 (output value) or 0x04 (output-enable, 1 = drive) reaches `gpio_out`/`gpio_oe` after the write edge. Reading either offset returns the written value and never the pad level.
- R3: Offset 0x08 returns the pad levels after a two-flop synchroniser. A pad change presented before clock edge k is visible in a read after edge k+1 and not after edge k.
- R4: Pins 0–15 take their 2-bit mode from the word at 0x0C, and pins 16–31 from the word at 0x10. Pin n uses bits [2·(n mod 16)+1 : 2·(n mod 16)]. The codes are 00 low level, 01 high level, 10 rising edge, 11 falling edge. Both words read back as written.
- R5: A level-mode pin sets its flag on every cycle its level is active. This includes the cycle right after a write-one clear.
- R6: An edge-mode pin sets its flag once per matching transition. A pad change before edge k sets the flag at edge k+2. A steady level leaves a cleared flag at 0.
- R7: When a pin's bit in the word at 0x1C is 1, the pin flags on both rising and falling transitions and its 2-bit mode field is ignored.
- R8: A write to offset 0x18 clears every flag bit written as 1 and leaves bits written as 0 unchanged. If a detection and a clear hit the same bit on the same edge, the bit ends up set.
- R9: `irq_lo` is the OR over pins 0–15 of flag AND mask, and `irq_hi` is the same over pins 16–31. A mask bit of 1 enables its pin. The mask word is at 0x14.
- R10: A write to the pad-level offset 0x08 changes no register, and the word keeps reading the pad levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, takes effect on the rising clock edge |
| bus_addr | input | ADDR_W (5) | Byte address of the word; low two bits must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| pad_in | input | PINS (32) | Asynchronous pad levels |
| gpio_out | output | PINS (32) | Output value register |
| gpio_oe | output | PINS (32) | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
A wrong synchroniser depth or edge reference shows up as a flag word changing one cycle too early or too late after a pad toggle. The bench samples the flag word on both the second and the third edge after each toggle for this reason. A wrong mode decode or field placement sets a flag on the wrong pin or in the wrong mode within three cycles of the toggle. Sweeping every pin through all five trigger settings catches it there. A broken clear priority or mask gating is visible on the read right after the clear write, or on the interrupt lines in the same cycle the flag changes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_W = 32;

  // word index = byte offset / 4
  localparam logic [2:0] IDX_DATA    = 3'd0;
  localparam logic [2:0] IDX_DIR     = 3'd1;
  localparam logic [2:0] IDX_PAD     = 3'd2;
  localparam logic [2:0] IDX_CFG_LO  = 3'd3;
  localparam logic [2:0] IDX_CFG_HI  = 3'd4;
  localparam logic [2:0] IDX_MASK    = 3'd5;
  localparam logic [2:0] IDX_FLAG    = 3'd6;
  localparam logic [2:0] IDX_ANYEDGE = 3'd7;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  lvl,
  input  logic [REG_W-1:0] cfg_lo,
  input  logic [REG_W-1:0] cfg_hi,
  input  logic [PINS-1:0]  any_edge,
  output logic [PINS-1:0]  hit,
  output logic [PINS-1:0]  prev_o
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign prev_o = prev;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    localparam int SLOT = n % HALF;
    trig_e mode;
    logic  rise, fall, h;

    if (n < HALF) begin : g_lo
      assign mode = trig_e'(cfg_lo[2*SLOT +: 2]);
    end else begin : g_hi
      assign mode = trig_e'(cfg_hi[2*SLOT +: 2]);
    end

    assign rise = lvl[n] & ~prev[n];
    assign fall = ~lvl[n] & prev[n];

    always_comb begin
      if (any_edge[n]) begin
        h = rise | fall;
      end else begin
        unique case (mode)
          TRIG_LOW:  h = ~lvl[n];
          TRIG_HIGH: h = lvl[n];
          TRIG_RISE: h = rise;
          TRIG_FALL: h = fall;
          default:   h = 1'b0;
        endcase
      end
    end

    assign hit[n] = h;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] hit,
  input  logic [PINS-1:0] clr,
  input  logic [PINS-1:0] mask,
  output logic [PINS-1:0] flags,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int HALF = PINS / 2;

  // a detection on the same edge as a clear keeps the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | hit;
  end

  logic [PINS-1:0] req;
  assign req    = flags & mask;
  assign irq_lo = |req[HALF-1:0];
  assign irq_hi = |req[PINS-1:HALF];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   gpio_out,
  output logic [PINS-1:0]   gpio_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 3;

  logic [PINS-1:0]  out_q, dir_q, mask_q, both_q;
  logic [REG_W-1:0] cfg_lo_q, cfg_hi_q;
  logic [PINS-1:0]  pad_sync, pad_prev, hit, clr, flags;

  logic [IDX_W-1:0] word_idx;
  logic             addr_ok, wr_go;

  assign word_idx = bus_addr[IDX_LSB +: IDX_W];
  assign addr_ok  = (bus_addr[IDX_LSB-1:0] == '0) &&
                    ((bus_addr >> (IDX_LSB + IDX_W)) == '0);
  assign wr_go    = bus_wen && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      both_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (wr_go) begin
      case (word_idx)
        IDX_DATA:    out_q    <= bus_wdata[PINS-1:0];
        IDX_DIR:     dir_q    <= bus_wdata[PINS-1:0];
        IDX_CFG_LO:  cfg_lo_q <= bus_wdata;
        IDX_CFG_HI:  cfg_hi_q <= bus_wdata;
        IDX_MASK:    mask_q   <= bus_wdata[PINS-1:0];
        IDX_ANYEDGE: both_q   <= bus_wdata[PINS-1:0];
        default:     ;
      endcase
    end
  end

  assign clr = (wr_go && word_idx == IDX_FLAG) ? bus_wdata[PINS-1:0] : '0;

  gpio_pad_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  gpio_trig_detect #(.PINS(PINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (pad_sync),
    .cfg_lo   (cfg_lo_q),
    .cfg_hi   (cfg_hi_q),
    .any_edge (both_q),
    .hit      (hit),
    .prev_o   (pad_prev)
  );

  gpio_irq_status #(.PINS(PINS)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .clr    (clr),
    .mask   (mask_q),
    .flags  (flags),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      case (word_idx)
        IDX_DATA:    bus_rdata[PINS-1:0] = out_q;
        IDX_DIR:     bus_rdata[PINS-1:0] = dir_q;
        IDX_PAD:     bus_rdata[PINS-1:0] = pad_sync;
        IDX_CFG_LO:  bus_rdata           = cfg_lo_q;
        IDX_CFG_HI:  bus_rdata           = cfg_hi_q;
        IDX_MASK:    bus_rdata[PINS-1:0] = mask_q;
        IDX_FLAG:    bus_rdata[PINS-1:0] = flags;
        IDX_ANYEDGE: bus_rdata[PINS-1:0] = both_q;
        default:     bus_rdata           = '0;
      endcase
    end
  end

  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wen,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   gpio_out,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [PINS-1:0]   flags,
  input logic [PINS-1:0]   mask_q,
  input logic [PINS-1:0]   pad_sync,
  input logic [PINS-1:0]   pad_prev,
  input logic [REG_W-1:0]  cfg_lo_q,
  input logic [PINS-1:0]   both_q
);
  localparam int HALF = PINS / 2;

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  logic wr_flag, wr_data;
  assign wr_flag = bus_wen && bus_addr == ADDR_W'({IDX_FLAG, 2'b00});
  assign wr_data = bus_wen && bus_addr == ADDR_W'({IDX_DATA, 2'b00});

  // R3: pad word lags the pins by exactly two edges
  p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> (pad_sync == $past(pad_in, 2)));

  // R8: a flag only falls on an edge that carried a clear write
  p_clear_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && (|($past(flags) & ~flags))) |-> $past(wr_flag));

  // R9: fully masked halves keep their line low
  p_lo_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[HALF-1:0] == '0) |-> !irq_lo);
  p_hi_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[PINS-1:HALF] == '0) |-> !irq_hi);

  // R6: pin 0 in rising mode with a steady pad keeps a clear flag clear
  p_edge_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lo_q[1:0] == 2'b10 && !both_q[0] && !flags[0] &&
     pad_sync[0] == pad_prev[0]) |=> !flags[0]);

  // R2: a write to the output word shows on the pins after the edge
  p_out_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && $past(wr_data)) |-> (gpio_out == $past(bus_wdata[PINS-1:0])));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wen   (bus_wen),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_in    (pad_in),
  .gpio_out  (gpio_out),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .flags     (flags),
  .mask_q    (mask_q),
  .pad_sync  (pad_sync),
  .pad_prev  (pad_prev),
  .cfg_lo_q  (cfg_lo_q),
  .both_q    (both_q)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14,
                         A_FLAG = 5'h18, A_ANY = 5'h1C;

  // expected flag of the tested pin per mode (bit index = mode: low, high, rise, fall, any)
  localparam logic [4:0] E_SETTLE = 5'b00001, E_UP_EARLY = 5'b00001, E_UP = 5'b10111,
                         E_UP_CLR = 5'b00010, E_DN_EARLY = 5'b00010, E_DN = 5'b11011;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pad_in, gpio_out, gpio_oe;
  logic        irq_lo, irq_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input int p, input int m);
    logic [31:0] w, lo, hi, v, bit_p;
    string rq;
    int sh;
    sh    = 2 * (p % 16);
    bit_p = 32'h1 << p;
    w     = (32'hAAAA_AAAA & ~(32'h3 << sh)) | (32'((m == 4) ? 0 : m) << sh);
    lo    = (p < 16) ? w : 32'hAAAA_AAAA;
    hi    = (p < 16) ? 32'hAAAA_AAAA : w;
    rq    = (m < 2) ? "R5" : (m < 4) ? "R6" : "R7";
    wr(A_CLO, lo);
    wr(A_CHI, hi);
    wr(A_ANY, (m == 4) ? bit_p : 32'h0);
    wr(A_MASK, ~bit_p);
    rd(A_CLO, v); chk("R4", "mode word lo", v, lo);
    rd(A_CHI, v); chk("R4", "mode word hi", v, hi);
    step(3);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, v); chk(rq, "settled after clear", v, E_SETTLE[m] ? bit_p : 32'h0);
    pad_in[p] = 1'b1;
    step(2);
    rd(A_FLAG, v); chk(rq, "rise edge k+1", v, E_UP_EARLY[m] ? bit_p : 32'h0);
    step(1);
    rd(A_FLAG, v); chk(rq, "rise edge k+2", v, E_UP[m] ? bit_p : 32'h0);
    chk("R9", "masked irq_lo", {31'h0, irq_lo}, 32'h0);
    chk("R9", "masked irq_hi", {31'h0, irq_hi}, 32'h0);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, v); chk("R8", "clear while high", v, E_UP_CLR[m] ? bit_p : 32'h0);
    wr(A_MASK, bit_p);
    pad_in[p] = 1'b0;
    step(2);
    rd(A_FLAG, v); chk(rq, "fall edge k+1", v, E_DN_EARLY[m] ? bit_p : 32'h0);
    step(1);
    rd(A_FLAG, v); chk(rq, "fall edge k+2", v, E_DN[m] ? bit_p : 32'h0);
    chk("R9", "irq_lo", {31'h0, irq_lo}, {31'h0, (p < 16) && E_DN[m]});
    chk("R9", "irq_hi", {31'h0, irq_hi}, {31'h0, (p >= 16) && E_DN[m]});
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); chk("R8", "write zero keeps", v, E_DN[m] ? bit_p : 32'h0);
  endtask

  initial begin
    logic [31:0] v, pat, prev;
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    step(3);
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v); chk("R1", "word in reset", v, 32'h0);
    end
    chk("R1", "irq in reset", {30'h0, irq_hi, irq_lo}, 32'h0);
    chk("R1", "pins in reset", gpio_out | gpio_oe, 32'h0);
    rst_n = 1'b1;
    step(3);
    foreach (v[i]) v[i] = 1'b0;
    rd(A_DATA, v); chk("R1", "out word", v, 32'h0);
    rd(A_DIR, v);  chk("R1", "dir word", v, 32'h0);
    rd(A_MASK, v); chk("R1", "mask word", v, 32'h0);
    rd(A_ANY, v);  chk("R1", "any-edge word", v, 32'h0);
    rd(A_CLO, v);  chk("R1", "mode lo word", v, 32'h0);
    chk("R1", "irq after reset", {30'h0, irq_hi, irq_lo}, 32'h0);

    for (int i = 0; i < 32; i++) begin
      pat = (32'h1 << i) ^ (32'h0F0F_0F0F * 32'(i & 1));
      wr(A_DATA, pat);
      wr(A_DIR, ~pat);
      pad_in = ~pat;
      rd(A_DATA, v); chk("R2", "out readback", v, pat);
      rd(A_DIR, v);  chk("R2", "dir readback", v, ~pat);
      chk("R2", "gpio_out", gpio_out, pat);
      chk("R2", "gpio_oe", gpio_oe, ~pat);
    end
    wr(A_DATA, 32'h0);
    wr(A_DIR, 32'h0);

    pad_in = 32'h0;
    step(3);
    prev = 32'h0;
    for (int k = 0; k < 10; k++) begin
      pat = 32'h9E37_79B9 * 32'(k + 1);
      pad_in = pat;
      step(1);
      rd(A_PAD, v); chk("R3", "pad after one edge", v, prev);
      step(1);
      rd(A_PAD, v); chk("R3", "pad after two edges", v, pat);
      prev = pat;
    end

    pad_in = 32'h0F0F_3C3C;
    step(3);
    wr(A_PAD, 32'hFFFF_FFFF);
    rd(A_PAD, v);  chk("R10", "pad word after write", v, 32'h0F0F_3C3C);
    rd(A_DATA, v); chk("R10", "out word untouched", v, 32'h0);
    rd(A_DIR, v);  chk("R10", "dir word untouched", v, 32'h0);
    pad_in = 32'h0;
    step(4);

    for (int p = 0; p < 32; p++)
      for (int m = 0; m < 5; m++)
        run_case(p, m);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual %0d cycles expected completion", 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule